// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with a count-down watchdog behind a single 32-bit control and status word. A selectable prescaler turns the reference clock into count ticks, and a selectable interval sets how many ticks may pass before software must restart the count. When the interval runs out, the block raises an interrupt flag and can signal an interrupt. It then starts a fixed grace window. If software does not restart the count before the grace window also runs out, the block sets a sticky reset flag and can assert a system reset level.

Software restarts the count by writing the self-clearing restart bit. It pauses or resumes the count with the enable bit, and acknowledges flags by writing ones to them. Two reset inputs are provided. The core reset returns every field to its default but keeps the reset flag, so software can learn after reboot that the watchdog caused the reboot. The power-on reset also clears the reset flag.

Top module: `stage_watchdog`

## Requirements
- R1: After core reset the control word reads 0x00000400 (clock select 1, every other field 0 apart from the preserved reset flag), and irq_o and sys_rst_o are low.
- R2: The control word holds clock select at bits 11:10, a stored freeze bit at 9, enable at 7, interrupt enable at 6, interval select at 5:4, interrupt flag at 3, reset flag at 2 and reset enable at 1. Bits 31:12, 8 and 0 read as 0.
- R3: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 to it leaves the flag unchanged.
- R4: Writing 1 to bit 0 reloads the count with 2^(BASE_EXP + 2*interval) ticks and restarts the prescaler. Bit 0 always reads back 0. If the same write sets enable, the first tick follows the write after one full prescale period.
- R5: Clock select values 0, 1, 2 and 3 give one tick every 2^0, 2^PS_EXP1, 2^PS_EXP2 and 2^PS_EXP3 clocks. The defaults are 1, 256, 2048 and 65536.
- R6: When the count expires while enable is set and the interrupt flag is clear, the block sets the interrupt flag and reloads GRACE_CYC ticks. irq_o equals the interrupt flag AND interrupt enable.
- R7: When the count expires while the interrupt flag is set and reset enable is set, the block sets the reset flag and raises sys_rst_o. sys_rst_o then stays high until core reset, even if the flag is cleared.
- R8: After a second-stage expiry the count parks and raises no further event until a restart. If reset enable is clear, this expiry has no other effect.
- R9: Clearing enable without a restart freezes the count and the prescaler. Setting enable again resumes from the frozen count.
- R10: Core reset preserves the reset flag. The power-on reset clears it.
- R11: If an expiry and a write fall in the same clock, a flag set by the expiry wins over a write-1 clear of that flag, and a restart in that write cancels the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous core reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset, also clears the reset flag |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data for the control word |
| rd_data_o | output | 32 | Current control word |
| irq_o | output | 1 | Watchdog interrupt, level |
| sys_rst_o | output | 1 | System reset request, sticky level |

## Verification
A software write can land in the same clock as a count expiry. The bench provokes this by counting the prescaled ticks from a restart and timing the write so it hits the expiry edge exactly. It does this once with a clear of the interrupt flag, where the flag must read set afterwards, and once with a restart, where the flag must stay clear and the next expiry must move out by a full interval. A behavioural model built independently of the design, and checked every clock, judges the cycles around these collisions.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int B_SEL_LO  = 10;
  localparam int B_FRZ     = 9;
  localparam int B_EN      = 7;
  localparam int B_IE      = 6;
  localparam int B_IVL_LO  = 4;
  localparam int B_IRQF    = 3;
  localparam int B_RSTF    = 2;
  localparam int B_RSTEN   = 1;
  localparam int B_RESTART = 0;
  localparam int CTRL_W    = 12;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic       frz;
    logic       en;
    logic       ie;
    logic [1:0] ivl;
    logic       irq_flag;
    logic       rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{clk_sel: 2'd1, default: '0};
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned PS_EXP1 = 8,
  parameter int unsigned PS_EXP2 = 11,
  parameter int unsigned PS_EXP3 = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned PS_W = (PS_EXP3 > 0) ? PS_EXP3 : 1;
  localparam int unsigned EXPS [4] = '{0, PS_EXP1, PS_EXP2, PS_EXP3};

  logic [PS_W:0] lim [4];
  logic [PS_W:0] cnt_q;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim[g] = (PS_W+1)'((64'd1 << EXPS[g]) - 64'd1);
  end

  // >= keeps a tick coming if the divider shrinks mid-period
  assign tick_o = run_i && (cnt_q >= lim[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned BASE_EXP  = 14,
  parameter int unsigned GRACE_CYC = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [1:0] ivl_i,
  input  logic       park_i,
  output logic       expire_o
);
  localparam int unsigned CNT_W = BASE_EXP + 7;

  logic [CNT_W-1:0] tmo [4];
  logic [CNT_W-1:0] rem_q;

  for (genvar g = 0; g < 4; g++) begin : g_tmo
    assign tmo[g] = CNT_W'(1) << (BASE_EXP + 2*g);
  end

  assign expire_o = tick_i && (rem_q == CNT_W'(1)) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= tmo[ivl_i];
    end else if (tick_i && (rem_q != '0)) begin
      if (rem_q == CNT_W'(1)) rem_q <= park_i ? '0 : CNT_W'(GRACE_CYC);
      else                    rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              rst_flag_o,
  output logic              sys_rst_o
);
  ctrl_t ctrl_q;
  logic  rst_flag_q, sys_rst_q;
  logic  set_irq, set_rst, clr_irq, clr_rst;

  assign set_irq = expire_i && !ctrl_q.irq_flag;
  assign set_rst = expire_i && ctrl_q.irq_flag && ctrl_q.rst_en;
  assign clr_irq = wr_en_i && wr_data_i[B_IRQF];
  assign clr_rst = wr_en_i && wr_data_i[B_RSTF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST;
      sys_rst_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        ctrl_q.clk_sel <= wr_data_i[B_SEL_LO+:2];
        ctrl_q.frz     <= wr_data_i[B_FRZ];
        ctrl_q.en      <= wr_data_i[B_EN];
        ctrl_q.ie      <= wr_data_i[B_IE];
        ctrl_q.ivl     <= wr_data_i[B_IVL_LO+:2];
        ctrl_q.rst_en  <= wr_data_i[B_RSTEN];
      end
      // a set from expiry outranks a same-cycle clear
      ctrl_q.irq_flag <= (ctrl_q.irq_flag && !clr_irq) || set_irq;
      sys_rst_q       <= sys_rst_q || set_rst;
    end
  end

  // only power-on clears the reset flag
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) rst_flag_q <= 1'b0;
    else         rst_flag_q <= (rst_flag_q && !clr_rst) || set_rst;
  end

  assign ctrl_o     = ctrl_q;
  assign rst_flag_o = rst_flag_q;
  assign sys_rst_o  = sys_rst_q;
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP  = 14,
  parameter int unsigned GRACE_CYC = 1024,
  parameter int unsigned PS_EXP1   = 8,
  parameter int unsigned PS_EXP2   = 11,
  parameter int unsigned PS_EXP3   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  ctrl_t ctrl;
  logic  rst_flag, restart, tick, expire;
  logic  unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[31:CTRL_W];
  assign restart      = wr_en_i && wr_data_i[B_RESTART];

  wdt_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_ni     (por_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i[CTRL_W-1:0]),
    .expire_i   (expire),
    .ctrl_o     (ctrl),
    .rst_flag_o (rst_flag),
    .sys_rst_o  (sys_rst_o)
  );

  wdt_prescale #(
    .PS_EXP1 (PS_EXP1),
    .PS_EXP2 (PS_EXP2),
    .PS_EXP3 (PS_EXP3)
  ) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl.en),
    .clr_i  (restart),
    .sel_i  (ctrl.clk_sel),
    .tick_o (tick)
  );

  wdt_countdown #(
    .BASE_EXP  (BASE_EXP),
    .GRACE_CYC (GRACE_CYC)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .load_i   (restart),
    .ivl_i    (wr_data_i[B_IVL_LO+:2] & {2{restart}} | ctrl.ivl & {2{!restart}}),
    .park_i   (ctrl.irq_flag),
    .expire_o (expire)
  );

  assign rd_data_o = {20'd0, ctrl.clk_sel, ctrl.frz, 1'b0, ctrl.en, ctrl.ie,
                      ctrl.ivl, ctrl.irq_flag, rst_flag, ctrl.rst_en, 1'b0};
  assign irq_o     = ctrl.irq_flag && ctrl.ie;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        irq_o,
  input logic        sys_rst_o
);
  AST_RESTART_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] == 1'b0); // R4
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31:12] == 20'd0) && !rd_data_o[8]); // R2
  AST_FLAG_WRITE_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[3] && rd_data_o[3]) |=> rd_data_o[3]); // R3
  AST_IRQ_FLAG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[3]) |-> $past(rd_data_o[7])); // R6
  AST_IRQ_LOW_WITHOUT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[3] |-> !irq_o); // R6
  AST_RST_OUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> sys_rst_o); // R7
  AST_RST_OUT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(rd_data_o[3] && rd_data_o[1] && rd_data_o[7])); // R7
  AST_RST_FLAG_WITH_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[2]) |-> sys_rst_o); // R7
endmodule

bind stage_watchdog wdt_checker u_wdt_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/stage_watchdog_bench.sv
module stage_watchdog_bench;
  localparam int BASE = 2;
  localparam int GRACE = 8;
  localparam int EXPS [4] = '{0, 1, 2, 3};

  logic        clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd;
  logic        irq, sysr;
  logic        cmp_on = 1'b0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  stage_watchdog #(
    .BASE_EXP (BASE), .GRACE_CYC (GRACE),
    .PS_EXP1 (1), .PS_EXP2 (2), .PS_EXP3 (3)
  ) u_stage_watchdog (
    .clk_i (clk), .rst_ni (rst_n), .por_ni (por_n),
    .wr_en_i (wr_en), .wr_data_i (wr_data),
    .rd_data_o (rd), .irq_o (irq), .sys_rst_o (sysr)
  );

  // behavioural reference
  int m_sel, m_frz, m_en, m_ie, m_ivl, m_irqf, m_rf, m_rsten, m_rem, m_ps, m_sys;

  task automatic m_core_reset();
    m_sel = 1; m_frz = 0; m_en = 0; m_ie = 0; m_ivl = 0; m_irqf = 0;
    m_rsten = 0; m_rem = 0; m_ps = 0; m_sys = 0;
  endtask

  function automatic logic [31:0] m_word();
    return 32'(m_sel*1024 + m_frz*512 + m_en*128 + m_ie*64 + m_ivl*16
               + m_irqf*8 + m_rf*4 + m_rsten*2);
  endfunction

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) begin
      m_core_reset(); m_rf = 0;
    end else if (!rst_n) begin
      m_core_reset();
    end else begin
      int div, n_ps, n_rem;
      bit tick, rs, ex, s_irq, s_rst, c_irq, c_rst;
      div   = 1 << EXPS[m_sel];
      tick  = (m_en != 0) && (m_ps >= div - 1);
      rs    = wr_en && wr_data[0];
      ex    = tick && (m_rem == 1) && !rs;
      s_irq = ex && (m_irqf == 0);
      s_rst = ex && (m_irqf != 0) && (m_rsten != 0);
      c_irq = wr_en && wr_data[3];
      c_rst = wr_en && wr_data[2];
      n_ps  = rs ? 0 : (m_en != 0) ? (tick ? 0 : m_ps + 1) : m_ps;
      n_rem = m_rem;
      if (rs) n_rem = 1 << (BASE + 2*int'(wr_data[5:4]));
      else if (tick && m_rem != 0) n_rem = (m_rem == 1) ? ((m_irqf != 0) ? 0 : GRACE) : m_rem - 1;
      m_irqf = ((m_irqf != 0 && !c_irq) || s_irq) ? 1 : 0;
      m_rf   = ((m_rf != 0 && !c_rst) || s_rst) ? 1 : 0;
      if (s_rst) m_sys = 1;
      if (wr_en) begin
        m_sel = int'(wr_data[11:10]); m_frz = int'(wr_data[9]); m_en = int'(wr_data[7]);
        m_ie = int'(wr_data[6]); m_ivl = int'(wr_data[5:4]); m_rsten = int'(wr_data[1]);
      end
      m_ps = n_ps; m_rem = n_rem;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n && por_n) begin
      check("R2 model readback", rd, m_word());
      check("R6 model irq_o", 32'(irq), 32'((m_irqf != 0) && (m_ie != 0)));
      check("R7 model sys_rst_o", 32'(sysr), 32'(m_sys));
    end
  end

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic core_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    idle(3); por_n = 1'b1; rst_n = 1'b1; idle(1); cmp_on = 1'b1;
    // R1 reset state
    check("R1 reset word", rd, 32'h400);
    check("R1 reset irq_o", 32'(irq), 0);
    check("R1 reset sys_rst_o", 32'(sysr), 0);
    // R2 field placement, spare bits
    wr(32'hFFFF_FE76);
    check("R2 field readback", rd, 32'hE72);
    wr(32'h400);
    check("R2 restore", rd, 32'h400);
    // R4 R6: div 1, 4 ticks
    wr(32'h0C1);
    check("R4 restart reads zero", rd, 32'h0C0);
    idle(3);
    check("R4 no expiry before timeout", rd, 32'h0C0);
    idle(1);
    check("R6 first expiry flag", rd, 32'h0C8);
    check("R6 irq_o raised", 32'(irq), 1);
    // R8 grace expiry without reset enable
    idle(20);
    check("R8 no reset without enable", 32'(sysr), 0);
    check("R8 word unchanged", rd, 32'h0C8);
    // R3 write-one-to-clear
    wr(32'h0C0);
    check("R3 zero keeps flag", rd, 32'h0C8);
    wr(32'h0C8);
    check("R3 one clears flag", rd, 32'h0C0);
    check("R6 irq_o follows flag", 32'(irq), 0);
    idle(20);
    check("R8 count parked", rd, 32'h0C0);
    // R5 div 4, ivl 1 -> 64 clocks
    wr(32'h8D1);
    idle(63);
    check("R5 div4 before expiry", rd, 32'h8D0);
    idle(1);
    check("R5 div4 expiry", rd, 32'h8D8);
    // R5 div 8, ivl 0 -> 32 clocks
    wr(32'hCC9);
    idle(31);
    check("R5 div8 before expiry", rd, 32'hCC0);
    idle(1);
    check("R5 div8 expiry", rd, 32'hCC8);
    // R7 second stage with reset enable
    wr(32'hCC2);
    idle(70);
    check("R7 reset flag set", rd, 32'hCCE);
    check("R7 sys_rst_o high", 32'(sysr), 1);
    wr(32'hCC6);
    check("R7 sys_rst_o stays after flag clear", 32'(sysr), 1);
    check("R3 reset flag cleared", rd, 32'hCCA);
    // R10 core reset keeps reset flag: set it again first
    wr(32'h0C3);
    idle(14);
    check("R7 second run reset flag", rd, 32'h0CE);
    core_reset();
    check("R10 core reset keeps flag", rd, 32'h404);
    check("R10 core reset drops sys_rst_o", 32'(sysr), 0);
    wr(32'h404);
    check("R3 reset flag w1c", rd, 32'h400);
    wr(32'h0C3);
    idle(14);
    check("R10 flag before power-on", rd, 32'h0CE);
    cmp_on = 1'b0; por_n = 1'b0; rst_n = 1'b0; idle(2);
    por_n = 1'b1; rst_n = 1'b1; idle(1); cmp_on = 1'b1;
    check("R10 power-on clears flag", rd, 32'h400);
    // R9 pause and resume
    wr(32'h0D1);
    idle(5);
    wr(32'h050);
    idle(30);
    check("R9 paused no expiry", rd, 32'h050);
    wr(32'h0D0);
    idle(9);
    check("R9 resumed before expiry", rd, 32'h0D0);
    idle(1);
    check("R9 resumed expiry", rd, 32'h0D8);
    // R11 collisions
    wr(32'h0C9);
    idle(3);
    wr(32'h0C8);
    check("R11 expiry set beats clear", rd, 32'h0C8);
    wr(32'h0C9);
    idle(3);
    wr(32'h0C1);
    check("R11 restart cancels expiry", rd, 32'h0C0);
    idle(3);
    check("R11 reloaded interval", rd, 32'h0C0);
    idle(1);
    check("R4 expiry after reload", rd, 32'h0C8);
    finish_up();
  end
endmodule